// File: doc/BRIEF.md
# Decode-Stage Control-Transfer Resolver

This block lives in the decode stage of a five-stage pipeline. For the instruction currently in decode it classifies the opcode and function fields, evaluates the branch condition on two operands that have already passed through the decode-stage bypass, and computes the next-PC target. Conditional equal and not-equal branches, the absolute jump, the jump-and-link and the register jump are all resolved here instead of in execute. A taken transfer therefore costs one slot, and that slot is the architectural delay slot.

Results are registered at the end of the decode cycle. In the following cycle the fetch stage has already fetched the delay-slot instruction. It sees a one-cycle redirect pulse with the target PC and loads that target. For jump-and-link the block also presents the return address, which is the branch PC plus eight so that the return skips the delay slot, together with a write enable for register 31.

The block tracks which instruction is a delay slot. A control-transfer opcode found in a delay slot is not acted on.

Top module: `bru_resolver`

## Requirements
- R1: Conditional branch on equal (opcode 6'h04) redirects if and only if operand A equals operand B.
- R2: Conditional branch on not-equal (opcode 6'h05) redirects if and only if operand A differs from operand B.
- R3: A taken conditional branch targets PC+4 plus the sign-extended 32-bit immediate shifted left by 2, with wrap-around modulo 2^32.
- R4: The absolute jump (opcode 6'h02) always redirects. Its target is bits 31:28 of PC+4, followed by the 26-bit index, followed by two zero bits.
- R5: Jump-and-link (opcode 6'h03) redirects to the same target as R4. It also asserts the link write enable and presents PC+8 as the link value.
- R6: The register jump (opcode 6'h00 with function 6'h08) always redirects, and its target is operand A.
- R7: Outputs change on the clock edge that ends the decode cycle. The redirect flag is high for exactly one cycle per taken transfer.
- R8: Any other opcode, and opcode 6'h00 with any function other than 6'h08, gives redirect 0 and link enable 0.
- R9: The valid instruction that follows a control-transfer instruction, taken or not, is a delay slot. A control-transfer opcode in a delay slot gives redirect 0 and link enable 0, and it does not open a new delay slot.
- R10: A cycle with the decode-valid input low gives redirect 0 and link enable 0, and it leaves the delay-slot state unchanged.
- R11: While reset is asserted, redirect, link enable, target and link value are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid_i | input | 1 | Decode stage holds a valid instruction this cycle |
| op_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function field, used for opcode 0 |
| imm_sx_i | input | 32 | Sign-extended 16-bit immediate |
| jidx_i | input | 26 | Jump index field |
| pc_i | input | 32 | PC of the instruction in decode |
| opa_i | input | 32 | First operand (rs), already bypassed |
| opb_i | input | 32 | Second operand (rt), already bypassed |
| redirect_o | output | 1 | One-cycle pulse: fetch loads target_o |
| target_o | output | 32 | Resolved next-PC target |
| link_we_o | output | 1 | Write link_o into register 31 |
| link_o | output | 32 | Return address, PC+8 |

## Verification
The hardest situation to reach from the ports is a control transfer inside a delay slot, combined with the question of which instruction counts as a slot once bubbles are interleaved. The bench keeps its own delay-slot model and runs directed sequences for this. In one, a taken branch is followed by a bubble and then a jump-and-link, which must be ignored. The instruction after that must be honoured again. The opcode and function sweeps put a neutral instruction after every transfer, so each transfer is evaluated outside a slot. The target-formula corners use a PC whose increment carries into the top four bits, and negative branch offsets.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_JUMP    = 6'h02;
  localparam logic [5:0] OPC_JLINK   = 6'h03;
  localparam logic [5:0] OPC_BREQ    = 6'h04;
  localparam logic [5:0] OPC_BRNE    = 6'h05;
  localparam logic [5:0] FN_JREG     = 6'h08;

  typedef enum logic [2:0] {
    CT_NONE  = 3'd0,
    CT_BREQ  = 3'd1,
    CT_BRNE  = 3'd2,
    CT_JUMP  = 3'd3,
    CT_JLINK = 3'd4,
    CT_JREG  = 3'd5
  } ctl_e;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctl_e       cls_o
);
  always_comb begin
    cls_o = CT_NONE;
    unique case (op_i)
      OPC_BREQ:    cls_o = CT_BREQ;
      OPC_BRNE:    cls_o = CT_BRNE;
      OPC_JUMP:    cls_o = CT_JUMP;
      OPC_JLINK:   cls_o = CT_JLINK;
      OPC_SPECIAL: cls_o = (funct_i == FN_JREG) ? CT_JREG : CT_NONE;
      default:     cls_o = CT_NONE;
    endcase
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_e            cls_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            take_o
);
  logic same;
  assign same = (opa_i == opb_i);

  always_comb begin
    unique case (cls_i)
      CT_BREQ:                    take_o = same;
      CT_BRNE:                    take_o = !same;
      CT_JUMP, CT_JLINK, CT_JREG: take_o = 1'b1;
      default:                    take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int INSN_B = 4
) (
  input  ctl_e              cls_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [XLEN-7:0]   idx_i,
  input  logic [XLEN-1:0]   opa_i,
  output logic [XLEN-1:0]   tgt_o,
  output logic [XLEN-1:0]   link_o
);
  localparam int SH    = $clog2(INSN_B);
  localparam int IDX_W = XLEN - 6;
  localparam int TOP_W = XLEN - IDX_W - SH;

  logic [XLEN-1:0] pc_nx;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jp_tgt;

  assign pc_nx  = pc_i + XLEN'(INSN_B);
  assign link_o = pc_i + XLEN'(2 * INSN_B);
  assign br_tgt = pc_nx + (imm_i << SH);

  generate
    if (TOP_W > 0) begin : g_region
      assign jp_tgt = {pc_nx[XLEN-1 -: TOP_W], idx_i, {SH{1'b0}}};
    end else begin : g_flat
      assign jp_tgt = {idx_i, {SH{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (cls_i)
      CT_BREQ, CT_BRNE:  tgt_o = br_tgt;
      CT_JUMP, CT_JLINK: tgt_o = jp_tgt;
      CT_JREG:           tgt_o = opa_i;
      default:           tgt_o = pc_nx;
    endcase
  end
endmodule

// File: rtl/bru_resolver.sv
module bru_resolver
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid_i,
  input  logic [5:0]      op_i,
  input  logic [5:0]      funct_i,
  input  logic [XLEN-1:0] imm_sx_i,
  input  logic [XLEN-7:0] jidx_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_o
);
  ctl_e            cls;
  logic            take;
  logic [XLEN-1:0] tgt_c;
  logic [XLEN-1:0] link_c;

  bru_decode u_dec (.op_i(op_i), .funct_i(funct_i), .cls_o(cls));

  bru_cond #(.XLEN(XLEN)) u_cond (
    .cls_i(cls), .opa_i(opa_i), .opb_i(opb_i), .take_o(take)
  );

  bru_target #(.XLEN(XLEN)) u_tgt (
    .cls_i(cls), .pc_i(pc_i), .imm_i(imm_sx_i), .idx_i(jidx_i),
    .opa_i(opa_i), .tgt_o(tgt_c), .link_o(link_c)
  );

  logic slot_q, slot_d;
  logic accept;
  logic redir_d, lwe_d;
  logic tgt_en, link_en;

  always_comb begin
    accept  = id_valid_i && !slot_q;
    redir_d = accept && take;
    lwe_d   = accept && (cls == CT_JLINK);
    tgt_en  = redir_d;
    link_en = lwe_d;
    slot_d  = slot_q;
    if (id_valid_i) slot_d = (cls != CT_NONE) && !slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= 1'b0;
      redirect_o <= 1'b0;
      link_we_o  <= 1'b0;
    end else begin
      slot_q     <= slot_d;
      redirect_o <= redir_d;
      link_we_o  <= lwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_o <= '0;
    end else if (tgt_en) begin
      target_o <= tgt_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_o <= '0;
    end else if (link_en) begin
      link_o <= link_c;
    end
  end

  // R7
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(id_valid_i) |-> (!redirect_o && !link_we_o));

  // R5
  link_implies_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> redirect_o);

  // R9
  slot_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(id_valid_i && slot_q) |-> (!redirect_o && !link_we_o));

  // R1
  beq_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && $past(op_i == OPC_BREQ)) |-> $past(opa_i == opb_i));

  // R2
  bne_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && $past(op_i == OPC_BRNE)) |-> $past(opa_i != opb_i));
endmodule

// File: tb/test_bru_resolver.sv
module test_bru_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_valid_i;
  logic [5:0]  op_i, funct_i;
  logic [31:0] imm_sx_i, pc_i, opa_i, opb_i;
  logic [25:0] jidx_i;
  logic        redirect_o, link_we_o;
  logic [31:0] target_o, link_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit m_slot = 1'b0;

  always #4 clk = ~clk;

  bru_resolver i_bru_resolver (
    .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid_i), .op_i(op_i),
    .funct_i(funct_i), .imm_sx_i(imm_sx_i), .jidx_i(jidx_i), .pc_i(pc_i),
    .opa_i(opa_i), .opb_i(opb_i), .redirect_o(redirect_o),
    .target_o(target_o), .link_we_o(link_we_o), .link_o(link_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one decode cycle and check the outputs after the closing edge.
  task automatic issue(input bit v, input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] imm, input logic [25:0] idx,
                       input logic [31:0] pc, input logic [31:0] a,
                       input logic [31:0] b);
    bit is_beq, is_bne, is_j, is_jal, is_jr, is_ctl, elig, tk;
    logic [31:0] pc4, exp_t;
    string tag;
    is_beq = (op == 6'd4);
    is_bne = (op == 6'd5);
    is_j   = (op == 6'd2);
    is_jal = (op == 6'd3);
    is_jr  = (op == 6'd0) && (fn == 6'd8);
    is_ctl = is_beq | is_bne | is_j | is_jal | is_jr;
    elig   = v && !m_slot;
    tk     = elig && ((is_beq && a == b) || (is_bne && a != b) || is_j || is_jal || is_jr);
    pc4    = pc + 32'd4;
    exp_t  = is_jr ? a : (is_j | is_jal) ? {pc4[31:28], idx, 2'b00} : pc4 + (imm <<< 2);
    if (!v)               tag = "R10";
    else if (m_slot)      tag = "R9";
    else if (!is_ctl)     tag = "R8";
    else if (is_beq)      tag = "R1";
    else if (is_bne)      tag = "R2";
    else if (is_j)        tag = "R4";
    else if (is_jal)      tag = "R5";
    else                  tag = "R6";
    if (v) m_slot = is_ctl && !m_slot;

    @(negedge clk);
    id_valid_i = v; op_i = op; funct_i = fn; imm_sx_i = imm; jidx_i = idx;
    pc_i = pc; opa_i = a; opb_i = b;
    @(posedge clk);
    #1;
    chk(redirect_o == tk, tag, {31'd0, redirect_o}, {31'd0, tk});
    chk(link_we_o == (elig && is_jal), tag, {31'd0, link_we_o}, {31'd0, elig && is_jal});
    if (tk) chk(target_o == exp_t, (is_beq | is_bne) ? "R3" : tag, target_o, exp_t);
    if (elig && is_jal) chk(link_o == pc + 32'd8, "R5", link_o, pc + 32'd8);
  endtask

  task automatic nop_cycle(input logic [31:0] pc);
    issue(1'b1, 6'h00, 6'h20, 32'd0, 26'd0, pc, 32'd1, 32'd2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; id_valid_i = 1'b1; op_i = 6'd4; funct_i = 6'd0;
    imm_sx_i = 32'd1; jidx_i = 26'd1; pc_i = 32'h100; opa_i = 32'd0; opb_i = 32'd0;
    repeat (3) @(posedge clk);
    #1;
    // R11 outputs held at zero under reset even with a valid taken branch present
    chk(redirect_o == 1'b0, "R11", {31'd0, redirect_o}, 32'd0);
    chk(link_we_o == 1'b0, "R11", {31'd0, link_we_o}, 32'd0);
    chk(target_o == 32'd0, "R11", target_o, 32'd0);
    chk(link_o == 32'd0, "R11", link_o, 32'd0);
    @(negedge clk);
    id_valid_i = 1'b0;
    rst_n = 1'b1;

    // Opcode sweep, each followed by a neutral instruction (R1 R2 R3 R4 R5 R6 R8)
    for (int op = 0; op < 64; op++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] a, b, imm, pc;
        a   = (p == 3) ? 32'hFFFF_FFFF : 32'h0000_0005 + op;
        b   = (p == 0 || p == 3) ? a : a + 32'(p);
        imm = p[0] ? -32'(op * 3 + 1) : 32'(op * 5);
        pc  = 32'h1000_0000 + 32'(op * 256 + p * 16);
        issue(1'b1, 6'(op), 6'h08, imm, 26'h2AA_AAAA ^ 26'(op), pc, a, b);
        nop_cycle(pc + 4);
      end
    end

    // Function sweep under opcode 0: only 6'h08 redirects (R6, R8)
    for (int fn = 0; fn < 64; fn++) begin
      issue(1'b1, 6'h00, 6'(fn), 32'd0, 26'd0, 32'h0000_4000, 32'h0040_0000 + 32'(fn * 4), 32'd0);
      nop_cycle(32'h0000_4004);
    end

    // R4 R5: PC increment carries into the region bits
    issue(1'b1, 6'h02, 6'h00, 32'd0, 26'h3FF_FFFF, 32'hEFFF_FFFC, 32'd0, 32'd0);
    nop_cycle(32'hF000_0000);
    issue(1'b1, 6'h03, 6'h00, 32'd0, 26'h000_0001, 32'hEFFF_FFFC, 32'd0, 32'd0);
    nop_cycle(32'hF000_0000);
    // R3: large negative offset wrapping below zero
    issue(1'b1, 6'h04, 6'h00, 32'hFFFF_8000, 26'd0, 32'h0000_0010, 32'd7, 32'd7);
    nop_cycle(32'h14);

    // R9: taken branch, bubble, jal in slot ignored, next branch honoured
    issue(1'b1, 6'h04, 6'h00, 32'd3, 26'd0, 32'h200, 32'd9, 32'd9);
    issue(1'b0, 6'h00, 6'h00, 32'd0, 26'd0, 32'h0, 32'd0, 32'd0); // R7 pulse ends, R10
    issue(1'b1, 6'h03, 6'h00, 32'd0, 26'h123, 32'h204, 32'd0, 32'd0);
    issue(1'b1, 6'h05, 6'h00, 32'd2, 26'd0, 32'h300, 32'd1, 32'd2);
    // R9: not-taken branch still opens a slot; jr in it ignored
    issue(1'b1, 6'h04, 6'h00, 32'd2, 26'd0, 32'h400, 32'd1, 32'd2);
    issue(1'b1, 6'h00, 6'h08, 32'd0, 26'd0, 32'h404, 32'h800, 32'd0);
    issue(1'b1, 6'h00, 6'h08, 32'd0, 26'd0, 32'h408, 32'h900, 32'd0);
    // R10: invalid control opcodes never act and keep the slot state
    issue(1'b0, 6'h02, 6'h00, 32'd0, 26'h55, 32'h500, 32'd0, 32'd0);
    issue(1'b0, 6'h03, 6'h00, 32'd0, 26'h55, 32'h500, 32'd0, 32'd0);
    issue(1'b1, 6'h03, 6'h00, 32'd0, 26'h66, 32'h600, 32'd0, 32'd0);
    issue(1'b0, 6'h00, 6'h00, 32'd0, 26'd0, 32'h0, 32'd0, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule